// File: doc/BRIEF.md
# 2D Rectangle Copy and Fill Engine

This block is a small drawing engine for a linear frame buffer. Software programs a set of 32-bit registers: base addresses and line pitches for a source and a destination surface, source and destination coordinates, a rectangle width and height, a pixel format code, a raster operation code and a fill colour. Writing the height register launches the operation. The engine then either copies a source rectangle byte by byte to the destination, or paints the destination rectangle with a solid colour. Pixels are visited row-major from the top-left corner, and the source and destination areas are assumed not to overlap.

Before it touches memory, the engine checks the operation against the frame-buffer size. An operation that would reach past the end is dropped whole, as is one with an unsupported pixel format or raster code. After a completed copy the destination position moves right by the width and down by the height. After a completed fill it moves down only. Back-to-back commands therefore tile naturally. A compatibility input treats pitches as pixel counts and adds a display base to both surfaces.

The memory master port is byte wide, addresses bytes, and returns read data one cycle after a read strobe. `busy` is high from the cycle after the launching write until the operation retires. A register write offered while busy is refused, and `reg_wait` is raised for it.

Top module: `blit_engine`

## Requirements
- R1: The low 4 bits of the format register (offset 0x2C) set bytes per pixel: code 2 gives 1, codes 3 and 4 give 2, code 5 gives 3, and code 6 gives 4. Any other code makes the operation write nothing and leave the coordinates unchanged.
- R2: The raster code is bits 23:16 of the mix register (offset 0x30). 0xCC copies from the source; 0xF0, 0x00 and 0xFF fill. Any other code writes nothing and leaves the coordinates unchanged.
- R3: Code 0xF0 fills with the fill-colour register (offset 0x28) with its four bytes reversed. Byte k of each pixel (k = 0 first) takes bits 8k+7:8k of the fill word.
- R4: Code 0x00 fills with the word {pal0_rgb, 8'hFF}, and code 0xFF with {pal1_rgb, 8'hFF}. Bytes are placed as in R3.
- R5: Byte k of the pixel at column c and row r is at base + (y+r)*pitch + (x+c)*bpp + k. Bytes are visited k first, then c, then r. A copy reads the source byte with `mem_rd` and writes it on the following cycle.
- R6: The operation is dropped with no write if the destination base, or base + (dst_y+height)*pitch + dst_x, is at or beyond MEM_BYTES. For a copy, the same test with src_x and src_y (and the shared height) also applies to the source.
- R7: After a completed copy, dst_x grows by the width and dst_y by the height. After a completed fill, only dst_y grows by the height.
- R8: With compat_en high, each effective pitch is the pitch register times bytes per pixel, and disp_base is added to both the source and destination bases.
- R9: An accepted write to the height register (offset 0x24) starts an operation, and busy rises on the next edge. A write offered while busy raises reg_wait in the same cycle and is discarded.
- R10: Register offsets: dst base 0x00, dst pitch 0x04, src base 0x08, src pitch 0x0C, src x 0x10, src y 0x14, dst x 0x18, dst y 0x1C, width 0x20. After reset all are zero, busy is low, and no memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_wait | output | 1 | Write refused because the engine is busy |
| compat_en | input | 1 | Pitches in pixels, display base added |
| disp_base | input | 27 | Display base offset used in compatibility mode |
| pal0_rgb | input | 24 | Colour used by code 0x00 |
| pal1_rgb | input | 24 | Colour used by code 0xFF |
| mem_rd | output | 1 | Memory byte read strobe |
| mem_wr | output | 1 | Memory byte write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after mem_rd |
| busy | output | 1 | Operation in progress |

## Verification
A wrong byte or pixel counter shows up at once as a misplaced or miscoloured byte in the frame buffer, and the bench finds it when it compares the whole memory after each command pair. A wrong coordinate update after the first command does not show in that command's own bytes. It shows only when the second command lands at the wrong place, so each case runs two commands back to back. Wrong decoding of the format, the raster code or the bounds test shows as writes where none were due, or as a missing rectangle. An out-of-range write address is flagged the cycle it appears.

// File: rtl/blit_pkg.sv
// Shared constants and types of the 2D rectangle engine.
// Assumes byte-offset register addressing with 32-bit registers.
package blit_pkg;
    localparam int CRD_W = 16;
    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_DST_BASE  = 8'h00;
    localparam logic [REG_AW-1:0] OFF_DST_PITCH = 8'h04;
    localparam logic [REG_AW-1:0] OFF_SRC_BASE  = 8'h08;
    localparam logic [REG_AW-1:0] OFF_SRC_PITCH = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_SRC_X     = 8'h10;
    localparam logic [REG_AW-1:0] OFF_SRC_Y     = 8'h14;
    localparam logic [REG_AW-1:0] OFF_DST_X     = 8'h18;
    localparam logic [REG_AW-1:0] OFF_DST_Y     = 8'h1C;
    localparam logic [REG_AW-1:0] OFF_WIDTH     = 8'h20;
    localparam logic [REG_AW-1:0] OFF_HEIGHT    = 8'h24;
    localparam logic [REG_AW-1:0] OFF_FILL      = 8'h28;
    localparam logic [REG_AW-1:0] OFF_FORMAT    = 8'h2C;
    localparam logic [REG_AW-1:0] OFF_MIX       = 8'h30;

    localparam logic [7:0] RASTER_COPY  = 8'hCC;
    localparam logic [7:0] RASTER_PAT   = 8'hF0;
    localparam logic [7:0] RASTER_BLACK = 8'h00;
    localparam logic [7:0] RASTER_WHITE = 8'hFF;

    typedef enum logic [1:0] {OP_NONE, OP_COPY, OP_FILL} op_e;
    typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_RD, ST_WR, ST_FIN} st_e;

    typedef struct packed {
        logic [31:0]      dst_base;
        logic [31:0]      dst_pitch;
        logic [31:0]      src_base;
        logic [31:0]      src_pitch;
        logic [CRD_W-1:0] src_x;
        logic [CRD_W-1:0] src_y;
        logic [CRD_W-1:0] dst_x;
        logic [CRD_W-1:0] dst_y;
        logic [CRD_W-1:0] width;
        logic [CRD_W-1:0] height;
        logic [31:0]      fill;
        logic [3:0]       fmt;
        logic [7:0]       raster;
    } cfg_t;
endpackage

// File: rtl/blit_regs.sv
// Register file of the 2D engine. It stores accepted writes, signals a start
// on a height write, and advances the destination coordinates on request.
// Assumes wr_en is never high while an update pulse is active.
module blit_regs
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              upd_x,
    input  logic              upd_y,
    output cfg_t              cfg,
    output logic              start
);
    // Launch pulse: an accepted write to the height register
    always_comb start = wr_en && (addr == OFF_HEIGHT);

    // Register storage and the coordinate advance after an operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    OFF_DST_BASE:  cfg.dst_base  <= wdata;
                    OFF_DST_PITCH: cfg.dst_pitch <= wdata;
                    OFF_SRC_BASE:  cfg.src_base  <= wdata;
                    OFF_SRC_PITCH: cfg.src_pitch <= wdata;
                    OFF_SRC_X:     cfg.src_x     <= wdata[CRD_W-1:0];
                    OFF_SRC_Y:     cfg.src_y     <= wdata[CRD_W-1:0];
                    OFF_DST_X:     cfg.dst_x     <= wdata[CRD_W-1:0];
                    OFF_DST_Y:     cfg.dst_y     <= wdata[CRD_W-1:0];
                    OFF_WIDTH:     cfg.width     <= wdata[CRD_W-1:0];
                    OFF_HEIGHT:    cfg.height    <= wdata[CRD_W-1:0];
                    OFF_FILL:      cfg.fill      <= wdata;
                    OFF_FORMAT:    cfg.fmt       <= wdata[3:0];
                    OFF_MIX:       cfg.raster    <= wdata[23:16];
                    default: ;
                endcase
            end
            if (upd_x) cfg.dst_x <= cfg.dst_x + cfg.width;
            if (upd_y) cfg.dst_y <= cfg.dst_y + cfg.height;
        end
    end
endmodule

// File: rtl/blit_setup.sv
// Combinational set-up of an operation: pixel size, operation kind, fill word,
// effective bases and pitches, and the end-of-memory test for both surfaces.
// Assumes the registers are stable while an operation runs.
module blit_setup
    import blit_pkg::*;
#(
    parameter int MEM_BYTES = 1 << 20
) (
    input  cfg_t        cfg,
    input  logic        compat_en,
    input  logic [26:0] disp_base,
    input  logic [23:0] pal0_rgb,
    input  logic [23:0] pal1_rgb,
    output logic [2:0]  bpp,
    output op_e         op,
    output logic [31:0] fill_word,
    output logic [31:0] src_base_e,
    output logic [31:0] dst_base_e,
    output logic [31:0] src_pitch_e,
    output logic [31:0] dst_pitch_e,
    output logic        in_bounds
);
    localparam logic [47:0] MEM_L = 48'(MEM_BYTES);

    logic [47:0] src_end, dst_end;
    logic        src_ok, dst_ok;

    // Pixel size from the format code (0 = unsupported)
    always_comb begin
        case (cfg.fmt)
            4'd2:       bpp = 3'd1;
            4'd3, 4'd4: bpp = 3'd2;
            4'd5:       bpp = 3'd3;
            4'd6:       bpp = 3'd4;
            default:    bpp = 3'd0;
        endcase
    end

    // Operation kind and fill word from the raster code
    always_comb begin
        fill_word = '0;
        case (cfg.raster)
            RASTER_COPY:  op = OP_COPY;
            RASTER_PAT:   begin op = OP_FILL; fill_word = {cfg.fill[7:0], cfg.fill[15:8], cfg.fill[23:16], cfg.fill[31:24]}; end
            RASTER_BLACK: begin op = OP_FILL; fill_word = {pal0_rgb, 8'hFF}; end
            RASTER_WHITE: begin op = OP_FILL; fill_word = {pal1_rgb, 8'hFF}; end
            default:      op = OP_NONE;
        endcase
    end

    // Effective bases and pitches, with compatibility scaling
    always_comb begin
        src_base_e  = cfg.src_base + (compat_en ? 32'(disp_base) : 32'd0);
        dst_base_e  = cfg.dst_base + (compat_en ? 32'(disp_base) : 32'd0);
        src_pitch_e = compat_en ? cfg.src_pitch * 32'(bpp) : cfg.src_pitch;
        dst_pitch_e = compat_en ? cfg.dst_pitch * 32'(bpp) : cfg.dst_pitch;
    end

    // End-of-memory test on the row just below each rectangle
    always_comb begin
        dst_end = 48'(dst_base_e) + (48'(cfg.dst_y) + 48'(cfg.height)) * 48'(dst_pitch_e) + 48'(cfg.dst_x);
        src_end = 48'(src_base_e) + (48'(cfg.src_y) + 48'(cfg.height)) * 48'(src_pitch_e) + 48'(cfg.src_x);
        dst_ok  = (48'(dst_base_e) < MEM_L) && (dst_end < MEM_L);
        src_ok  = (48'(src_base_e) < MEM_L) && (src_end < MEM_L);
        in_bounds = dst_ok && (src_ok || (op != OP_COPY));
    end
endmodule

// File: rtl/blit_walker.sv
// Sequencer of the 2D engine. It walks bytes, columns and rows of the
// rectangle, drives the byte-wide memory port, and requests the coordinate
// advance when it finishes. Assumes one-cycle read latency and no overlap
// between source and destination.
module blit_walker
    import blit_pkg::*;
#(
    parameter int MEM_BYTES = 1 << 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  op_e              op,
    input  logic [2:0]       bpp,
    input  logic             in_bounds,
    input  logic [31:0]      fill_word,
    input  logic [31:0]      src_base_e,
    input  logic [31:0]      dst_base_e,
    input  logic [31:0]      src_pitch_e,
    input  logic [31:0]      dst_pitch_e,
    input  logic [CRD_W-1:0] src_x,
    input  logic [CRD_W-1:0] src_y,
    input  logic [CRD_W-1:0] dst_x,
    input  logic [CRD_W-1:0] dst_y,
    input  logic [CRD_W-1:0] width,
    input  logic [CRD_W-1:0] height,
    input  logic [7:0]       mem_rdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [31:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             busy,
    output logic             upd_x,
    output logic             upd_y
);
    st_e              st;
    logic             is_copy;
    logic [CRD_W-1:0] col, row;
    logic [1:0]       kb;
    logic [31:0]      sa, da;
    logic             last_b, last_c, last_r;

    // Byte addresses of the current source and destination byte
    always_comb begin
        sa = src_base_e + (32'(src_y) + 32'(row)) * src_pitch_e + (32'(src_x) + 32'(col)) * 32'(bpp) + 32'(kb);
        da = dst_base_e + (32'(dst_y) + 32'(row)) * dst_pitch_e + (32'(dst_x) + 32'(col)) * 32'(bpp) + 32'(kb);
        last_b = (3'(kb) == bpp - 3'd1);
        last_c = (col == width - 1'b1);
        last_r = (row == height - 1'b1);
    end

    // Memory port and update strobes decoded from the state
    always_comb begin
        mem_rd    = (st == ST_RD);
        mem_wr    = (st == ST_WR);
        mem_addr  = (st == ST_RD) ? sa : da;
        mem_wdata = is_copy ? mem_rdata : fill_word[{kb, 3'b000} +: 8];
        busy      = (st != ST_IDLE);
        upd_y     = (st == ST_FIN);
        upd_x     = (st == ST_FIN) && is_copy;
    end

    // State machine and byte/column/row counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; is_copy <= 1'b0;
            col <= '0; row <= '0; kb <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) st <= ST_CHECK;
                ST_CHECK: begin
                    col <= '0; row <= '0; kb <= '0;
                    is_copy <= (op == OP_COPY);
                    if (op == OP_NONE || bpp == 3'd0 || !in_bounds) st <= ST_IDLE;
                    else if (width == '0 || height == '0) st <= ST_FIN;
                    else st <= (op == OP_COPY) ? ST_RD : ST_WR;
                end
                ST_RD: st <= ST_WR;
                ST_WR: begin
                    if (!last_b) begin
                        kb <= kb + 2'd1;
                        st <= is_copy ? ST_RD : ST_WR;
                    end else begin
                        kb <= '0;
                        if (!last_c) begin
                            col <= col + 1'b1;
                            st <= is_copy ? ST_RD : ST_WR;
                        end else begin
                            col <= '0;
                            if (last_r) st <= ST_FIN;
                            else begin
                                row <= row + 1'b1;
                                st <= is_copy ? ST_RD : ST_WR;
                            end
                        end
                    end
                end
                ST_FIN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9
    access_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);
    // R5
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_wr && !mem_rd));
    // R6
    write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr < 32'(MEM_BYTES)));
    // R2
    copy_only_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> is_copy);
    // R7
    fill_keeps_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_y && !is_copy) |-> !upd_x);
endmodule

// File: rtl/blit_engine.sv
// Top of the 2D rectangle copy/fill engine. It refuses register writes while
// an operation runs and ties the register file, set-up and sequencer together.
// Assumes a byte-wide memory with one-cycle read latency.
module blit_engine
    import blit_pkg::*;
#(
    parameter int MEM_BYTES = 1 << 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        reg_wait,
    input  logic        compat_en,
    input  logic [26:0] disp_base,
    input  logic [23:0] pal0_rgb,
    input  logic [23:0] pal1_rgb,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        busy
);
    cfg_t        cfg;
    logic        wr_ok, start, upd_x, upd_y, in_bounds;
    logic [2:0]  bpp;
    op_e         op;
    logic [31:0] fill_word, src_base_e, dst_base_e, src_pitch_e, dst_pitch_e;

    // Hold-off: writes are accepted only while idle
    always_comb begin
        wr_ok    = reg_we && !busy;
        reg_wait = reg_we && busy;
    end

    blit_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .addr(reg_addr), .wdata(reg_wdata),
        .upd_x(upd_x), .upd_y(upd_y), .cfg(cfg), .start(start)
    );

    blit_setup #(.MEM_BYTES(MEM_BYTES)) u_setup (
        .cfg(cfg), .compat_en(compat_en), .disp_base(disp_base),
        .pal0_rgb(pal0_rgb), .pal1_rgb(pal1_rgb), .bpp(bpp), .op(op),
        .fill_word(fill_word), .src_base_e(src_base_e), .dst_base_e(dst_base_e),
        .src_pitch_e(src_pitch_e), .dst_pitch_e(dst_pitch_e), .in_bounds(in_bounds)
    );

    blit_walker #(.MEM_BYTES(MEM_BYTES)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bpp(bpp),
        .in_bounds(in_bounds), .fill_word(fill_word),
        .src_base_e(src_base_e), .dst_base_e(dst_base_e),
        .src_pitch_e(src_pitch_e), .dst_pitch_e(dst_pitch_e),
        .src_x(cfg.src_x), .src_y(cfg.src_y), .dst_x(cfg.dst_x), .dst_y(cfg.dst_y),
        .width(cfg.width), .height(cfg.height), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .upd_x(upd_x), .upd_y(upd_y)
    );

    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && busy) |-> reg_wait);
    // R9
    start_on_height_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && reg_addr == OFF_HEIGHT));
    // R10
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr));
endmodule

// File: tb/blit_engine_tb_top.sv
// Self-checking bench: sweeps formats and raster codes, bounds and
// compatibility cases; each case runs two commands and compares all memory.
module blit_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM = 1024;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wait, mem_rd, mem_wr, busy;
    logic        compat_en = 1'b0;
    logic [26:0] disp_base = '0;
    logic [23:0] pal0 = 24'h102030, pal1 = 24'hA0B0C0;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0] mem [MEM];
    logic [7:0] expm [MEM];
    int checks = 0, errors = 0, cycles = 0;

    // bench copies of the programmed registers
    int m_db, m_dp, m_sb, m_sp, m_sx, m_sy, m_dx, m_dy, m_w, m_h, m_fmt, m_rop;
    logic [31:0] m_fill;

    always #(CLK_PERIOD/2) clk = ~clk;

    blit_engine #(.MEM_BYTES(MEM)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wait(reg_wait), .compat_en(compat_en),
        .disp_base(disp_base), .pal0_rgb(pal0), .pal1_rgb(pal1),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
    );

    // byte memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr) begin
            if (mem_addr < MEM) mem[mem_addr[9:0]] <= mem_wdata;
            else begin
                errors++;
                $display("FAIL R6: write address %0d, expected below %0d", mem_addr, MEM);
            end
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: cycles %0d, expected at most 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // model of one command from the requirements (R1 to R8)
    task automatic model_op();
        int bpp, sp, dp, sb, db;
        logic [31:0] fw;
        longint dend, send;
        bit cp;
        case (m_fmt)
            2: bpp = 1; 3, 4: bpp = 2; 5: bpp = 3; 6: bpp = 4; default: bpp = 0;
        endcase
        if (bpp == 0) return;
        cp = (m_rop == 8'hCC);
        if (m_rop == 8'hF0) fw = {m_fill[7:0], m_fill[15:8], m_fill[23:16], m_fill[31:24]};
        else if (m_rop == 8'h00) fw = {pal0, 8'hFF};
        else if (m_rop == 8'hFF) fw = {pal1, 8'hFF};
        else if (!cp) return;
        sp = compat_en ? m_sp * bpp : m_sp;
        dp = compat_en ? m_dp * bpp : m_dp;
        sb = m_sb + (compat_en ? int'(disp_base) : 0);
        db = m_db + (compat_en ? int'(disp_base) : 0);
        dend = longint'(db) + longint'(m_dy + m_h) * dp + m_dx;
        send = longint'(sb) + longint'(m_sy + m_h) * sp + m_sx;
        if (db >= MEM || dend >= MEM) return;
        if (cp && (sb >= MEM || send >= MEM)) return;
        for (int r = 0; r < m_h; r++)
            for (int c = 0; c < m_w; c++)
                for (int k = 0; k < bpp; k++) begin
                    int da, sa;
                    da = db + (m_dy + r) * dp + (m_dx + c) * bpp + k;
                    sa = sb + (m_sy + r) * sp + (m_sx + c) * bpp + k;
                    expm[da] = cp ? expm[sa] : 8'(fw >> (8 * k));
                end
        if (cp) m_dx = (m_dx + m_w) & 16'hFFFF;
        m_dy = (m_dy + m_h) & 16'hFFFF;
    endtask

    // program all registers, run two commands, compare memory
    task automatic run_case(input string tag, input int db, input int dp, input int sb,
                            input int sp, input int fmt, input int rop, input bit poke);
        for (int i = 0; i < MEM; i++) begin mem[i] = 8'(i * 37 + 11); expm[i] = mem[i]; end
        m_db = db; m_dp = dp; m_sb = sb; m_sp = sp; m_sx = 1; m_sy = 2;
        m_dx = 2; m_dy = 1; m_w = 3; m_h = 2; m_fmt = fmt; m_rop = rop; m_fill = 32'h11223344;
        wr(8'h00, 32'(db)); wr(8'h04, 32'(dp)); wr(8'h08, 32'(sb)); wr(8'h0C, 32'(sp));
        wr(8'h10, 32'(m_sx)); wr(8'h14, 32'(m_sy)); wr(8'h18, 32'(m_dx)); wr(8'h1C, 32'(m_dy));
        wr(8'h20, 32'(m_w)); wr(8'h28, m_fill); wr(8'h2C, 32'(fmt)); wr(8'h30, 32'(rop) << 16);
        for (int n = 0; n < 2; n++) begin
            wr(8'h24, 32'(m_h));
            if (poke && n == 0) begin
                reg_we = 1'b1; reg_addr = 8'h18; reg_wdata = 32'd77; #1;
                checks++;
                if (!(busy && reg_wait)) begin
                    errors++;
                    $display("FAIL R9: busy=%0b reg_wait=%0b, expected 1 1", busy, reg_wait);
                end
                @(negedge clk); reg_we = 1'b0;
            end
            wait_idle();
            model_op();
        end
        checks++;
        for (int i = 0; i < MEM; i++)
            if (mem[i] !== expm[i]) begin
                errors++;
                $display("FAIL %s fmt=%0d rop=%02h: byte %0d actual %02h expected %02h",
                         tag, fmt, rop, i, mem[i], expm[i]);
                break;
            end
    endtask

    initial begin
        int rops[5] = '{8'hCC, 8'hF0, 8'h00, 8'hFF, 8'h5A};
        repeat (3) @(negedge clk);
        checks++;   // R10 reset state
        if (busy || reg_wait || mem_rd || mem_wr) begin
            errors++;
            $display("FAIL R10: busy/wait/rd/wr = %0b%0b%0b%0b, expected 0000", busy, reg_wait, mem_rd, mem_wr);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 R3 R4 R5 R7 sweep of formats and raster codes
        for (int f = 0; f < 8; f++)
            for (int r = 0; r < 5; r++)
                run_case("R1/R2/R3/R4/R5/R7", 512, 40, 64, 40, f, rops[r], (f == 6 && r == 0));
        // R6 first command just inside, second beyond the end
        run_case("R6_edge", 900, 40, 64, 40, 6, 8'hCC, 1'b0);
        run_case("R6_src", 512, 40, 1024, 40, 2, 8'hCC, 1'b0);
        run_case("R6_fill", 2000, 40, 64, 40, 2, 8'hF0, 1'b0);
        // R8 compatibility mode
        compat_en = 1'b1; disp_base = 27'h40;
        run_case("R8_copy", 400, 10, 100, 10, 3, 8'hCC, 1'b0);
        run_case("R8_fill", 400, 10, 100, 10, 5, 8'h00, 1'b0);
        compat_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule